// File: doc/BRIEF.md
# UART Interrupt Status and Enable Unit

This unit gathers the event sources of a serial port into one 14-bit pending register and masks it with a 14-bit enable register of the same layout. A single active-high, level-sensitive interrupt line is raised while any pending bit is also enabled.

The status register has these properties:

- An event always records its pending bit, whether or not that bit is enabled. The enable mask only decides what reaches the interrupt line.
- Software acknowledges events by writing ones to the status register. The usual sequence is to read the status and then write the same value back.
- The CTS toggle bit is generated inside the unit from a synchronised CTS level.

There is no streaming data path here. Every pin is a plain control or status signal, so no valid/ready handshake and no back-pressure apply. A write strobe is acted on in the cycle it is high.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `status_o` and `enable_o` are zero and `irq_o` is low.
- R2: A high on `evt_i[k]` at a rising clock edge sets `status_o[k]` from the next cycle on, whether or not `enable_o[k]` is set. The bit then stays set until it is cleared. The bit positions are fixed:
  - 0: TX data empty
  - 1: RX data full
  - 2: TX FIFO almost empty
  - 3: TX FIFO empty
  - 4: RX FIFO almost full
  - 5: RX FIFO full
  - 6: TX underrun
  - 7: RX overrun
  - 8: parity error
  - 9: frame error
  - 10: CTS toggle
  - 11: RX timeout
  - 12: break done
  - 13: bus error response
- R3: A cycle with `st_wr_i` high clears every status bit whose `st_wdata_i` bit is 1. Bits written with 0 keep their value. Writing back a value that was read clears exactly those bits.
- R4: If an event and a write-1 clear hit the same status bit in the same cycle, the bit is set after that cycle.
- R5: `irq_o` is high exactly when some bit is set in both `status_o` and `enable_o`. It stays high for as long as that holds; it is a level, not a pulse.
- R6: A change of `cts_i` in either direction between two consecutive clock edges sets status bit 10. The level `cts_i` has when the unit leaves reset is taken as the reference and never sets the bit on its own. `evt_i[10]` also sets bit 10.
- R7: A cycle with `ie_wr_i` high loads all 14 bits of `ie_wdata_i` into `enable_o`, visible in the next cycle. An enable write never changes `status_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 14 | Event pulses or levels, one per status bit |
| cts_i | input | 1 | Synchronised CTS level |
| st_wr_i | input | 1 | Status write strobe (write-1-to-clear) |
| st_wdata_i | input | 14 | Status write data; ones clear bits |
| ie_wr_i | input | 1 | Enable register write strobe |
| ie_wdata_i | input | 14 | New enable mask |
| status_o | output | 14 | Pending event register |
| enable_o | output | 14 | Enable mask register |
| irq_o | output | 1 | Level-high interrupt request |

## Verification
The main function is tried with the following input patterns:

- Events arriving while their bit is masked show that latching and masking are separate.
- Zero writes next to one-writes show that a clear affects only the bits written with one.
- A clear that collides with a fresh event on the same bit, next to a clear of a different bit, tells the set-wins rule apart from an ordinary clear.
- CTS is held high through reset and then toggled both ways. This separates a true level change from the reference level captured at reset.
- An interrupt held over several idle cycles tells a level output apart from a pulse.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int unsigned NUM_SRC = 14;

  localparam int unsigned B_TX_DATA_EMPTY  = 0;
  localparam int unsigned B_RX_DATA_FULL   = 1;
  localparam int unsigned B_TXF_ALMOST_MT  = 2;
  localparam int unsigned B_TXF_EMPTY      = 3;
  localparam int unsigned B_RXF_ALMOST_FUL = 4;
  localparam int unsigned B_RXF_FULL       = 5;
  localparam int unsigned B_TX_UNDERRUN    = 6;
  localparam int unsigned B_RX_OVERRUN     = 7;
  localparam int unsigned B_PARITY_ERR     = 8;
  localparam int unsigned B_FRAME_ERR      = 9;
  localparam int unsigned B_CTS_TOGGLE     = 10;
  localparam int unsigned B_RX_TIMEOUT     = 11;
  localparam int unsigned B_BREAK_DONE     = 12;
  localparam int unsigned B_BUS_ERR        = 13;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/uirq_cts_edge.sv
module uirq_cts_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_i,
  output logic toggle_o
);
  logic prev_q;
  logic vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= cts_i;
      vld_q  <= 1'b1;
    end
  end

  assign toggle_o = vld_q & (cts_i ^ prev_q);

  // R6: no toggle can be reported in the first cycle out of reset
  p_no_first_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !toggle_o);
endmodule

// File: rtl/uirq_status_bank.sv
module uirq_status_bank #(
  parameter int unsigned WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] clr_mask_i,
  output logic [WIDTH-1:0] status_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        bit_q <= 1'b0;
      else if (set_i[i])
        bit_q <= 1'b1;
      else if (clr_en_i && clr_mask_i[i])
        bit_q <= 1'b0;
    end
    assign status_o[i] = bit_q;
  end

  // R3: bits written with one (and not hit by an event) are clear afterwards
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> ((status_o & $past(clr_mask_i & ~set_i)) == '0));

  // R4 / R2: any event leaves its bit set, even against a clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

  // R2: with no event and no write the register holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en_i && set_i == '0) |=> $stable(status_o));
endmodule

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg #(
  parameter int unsigned WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] enable_o
);
  logic [WIDTH-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      en_q <= '0;
    else if (wr_i)
      en_q <= wdata_i;
  end

  assign enable_o = en_q;

  // R7: a write loads the full mask
  p_ie_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (enable_o == $past(wdata_i)));

  // R7: without a write the mask holds
  p_ie_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(enable_o));
endmodule

// File: rtl/uirq_irq_merge.sv
module uirq_irq_merge #(
  parameter int unsigned WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] status_i,
  input  logic [WIDTH-1:0] enable_i,
  output logic             irq_o
);
  logic [WIDTH-1:0] live;

  assign live  = status_i & enable_i;
  assign irq_o = |live;

  // R5: a zero mask keeps the line low
  p_mask_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i == '0) |-> !irq_o);

  // R5: the line is never high with nothing pending
  p_need_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_i != '0));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int unsigned W = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         cts_i,
  input  logic         st_wr_i,
  input  logic [W-1:0] st_wdata_i,
  input  logic         ie_wr_i,
  input  logic [W-1:0] ie_wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         irq_o
);
  logic         cts_tog;
  logic [W-1:0] set_vec;

  uirq_cts_edge u_cts (
    .clk      (clk),
    .rst_n    (rst_n),
    .cts_i    (cts_i),
    .toggle_o (cts_tog)
  );

  always_comb begin
    set_vec = evt_i;
    set_vec[B_CTS_TOGGLE] = evt_i[B_CTS_TOGGLE] | cts_tog;
  end

  uirq_status_bank #(.WIDTH(W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_vec),
    .clr_en_i   (st_wr_i),
    .clr_mask_i (st_wdata_i),
    .status_o   (status_o)
  );

  uirq_enable_reg #(.WIDTH(W)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (ie_wr_i),
    .wdata_i  (ie_wdata_i),
    .enable_o (enable_o)
  );

  uirq_irq_merge #(.WIDTH(W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_o),
    .enable_i (enable_o),
    .irq_o    (irq_o)
  );

  // R6: a detected CTS change is recorded in its status bit
  p_cts_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cts_tog |=> status_o[B_CTS_TOGGLE]);

  // R7: an enable write alone does not disturb pending bits
  p_ie_no_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_wr_i && !st_wr_i && evt_i == '0 && !cts_tog) |=> $stable(status_o));
endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
  localparam int W = 14;

  typedef struct packed {
    logic [W-1:0] evt;
    logic         swr;
    logic [W-1:0] swd;
    logic         iwr;
    logic [W-1:0] iwd;
    logic [W-1:0] est;
    logic [W-1:0] een;
    logic         eirq;
  } vec_t;

  // state accumulates from one row to the next
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{14'h0001, 1'b0, 14'h0000, 1'b0, 14'h0000, 14'h0001, 14'h0000, 1'b0}, // R2 latch while masked
    '{14'h0000, 1'b0, 14'h0000, 1'b1, 14'h0001, 14'h0001, 14'h0001, 1'b1}, // R5 R7 enable raises irq
    '{14'h2000, 1'b0, 14'h0000, 1'b0, 14'h0000, 14'h2001, 14'h0001, 1'b1}, // R2 bus error bit 13
    '{14'h0000, 1'b1, 14'h0000, 1'b0, 14'h0000, 14'h2001, 14'h0001, 1'b1}, // R3 zero write no effect
    '{14'h0000, 1'b1, 14'h0001, 1'b0, 14'h0000, 14'h2000, 14'h0001, 1'b0}, // R3 clear bit 0
    '{14'h0000, 1'b0, 14'h0000, 1'b1, 14'h2000, 14'h2000, 14'h2000, 1'b1}, // R7 new mask
    '{14'h0100, 1'b1, 14'h2100, 1'b0, 14'h0000, 14'h0100, 14'h2000, 1'b0}, // R4 set wins on bit 8
    '{14'h0A0A, 1'b0, 14'h0000, 1'b0, 14'h0000, 14'h0B0A, 14'h2000, 1'b0}, // R2 several bits
    '{14'h0000, 1'b0, 14'h0000, 1'b1, 14'h0002, 14'h0B0A, 14'h0002, 1'b1}, // R5
    '{14'h0000, 1'b1, 14'h0B0A, 1'b0, 14'h0000, 14'h0000, 14'h0002, 1'b0}, // R3 write back read value
    '{14'h3FFF, 1'b0, 14'h0000, 1'b0, 14'h0000, 14'h3FFF, 14'h0002, 1'b1}, // R2 all bits
    '{14'h0000, 1'b1, 14'h3FFF, 1'b1, 14'h0000, 14'h0000, 14'h0000, 1'b0}  // R3 R7
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] evt_i = '0;
  logic         cts_i = 1'b0;
  logic         st_wr_i = 1'b0;
  logic [W-1:0] st_wdata_i = '0;
  logic         ie_wr_i = 1'b0;
  logic [W-1:0] ie_wdata_i = '0;
  logic [W-1:0] status_o;
  logic [W-1:0] enable_o;
  logic         irq_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .cts_i      (cts_i),
    .st_wr_i    (st_wr_i),
    .st_wdata_i (st_wdata_i),
    .ie_wr_i    (ie_wr_i),
    .ie_wdata_i (ie_wdata_i),
    .status_o   (status_o),
    .enable_o   (enable_o),
    .irq_o      (irq_o)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_cycle();
    evt_i = '0; st_wr_i = 1'b0; ie_wr_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cts_i = 1'b1;                              // held high through reset (R6)
    repeat (3) @(negedge clk);
    chk("R1 status in reset", status_o, '0);
    chk("R1 enable in reset", enable_o, '0);
    chk("R1 irq in reset", {13'b0, irq_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", status_o, '0);
    chk("R6 reference level not a toggle", status_o, '0);
    @(negedge clk);
    chk("R6 steady cts", {13'b0, status_o[10]}, '0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      evt_i = VECS[k].evt;
      st_wr_i = VECS[k].swr; st_wdata_i = VECS[k].swd;
      ie_wr_i = VECS[k].iwr; ie_wdata_i = VECS[k].iwd;
      @(negedge clk);
      chk($sformatf("R2/R3/R4 row %0d status", k), status_o, VECS[k].est);
      chk($sformatf("R7 row %0d enable", k), enable_o, VECS[k].een);
      chk($sformatf("R5 row %0d irq", k), {13'b0, irq_o}, {13'b0, VECS[k].eirq});
    end
    idle_cycle();

    // R6: falling and rising CTS changes
    cts_i = 1'b0;
    @(negedge clk);
    chk("R6 falling cts sets bit 10", status_o, 14'h0400);
    cts_i = 1'b0; st_wr_i = 1'b1; st_wdata_i = 14'h0400;
    @(negedge clk);
    chk("R6 clear bit 10", status_o, '0);
    st_wr_i = 1'b0;
    cts_i = 1'b1;
    @(negedge clk);
    chk("R6 rising cts sets bit 10", status_o, 14'h0400);

    // R4: cts change colliding with a clear of bit 10
    cts_i = 1'b0; st_wr_i = 1'b1; st_wdata_i = 14'h0400;
    @(negedge clk);
    chk("R4 cts toggle beats clear", status_o, 14'h0400);
    st_wr_i = 1'b0;

    // R5: level persists over idle cycles
    ie_wr_i = 1'b1; ie_wdata_i = 14'h0400;
    @(negedge clk);
    ie_wr_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 irq stays high while pending", {13'b0, irq_o}, 14'h0001);
    chk("R7 enable write left status alone", status_o, 14'h0400);

    // R5: masking a pending bit drops irq
    ie_wr_i = 1'b1; ie_wdata_i = 14'h3BFF;
    @(negedge clk);
    ie_wr_i = 1'b0;
    chk("R5 masked pending bit", {13'b0, irq_o}, '0);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 status cleared by reset", status_o, '0);
    chk("R1 enable cleared by reset", enable_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq low after reset", {13'b0, irq_o}, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule